// File: doc/BRIEF.md
# Infrared Pulse Timing Capture Receiver

This block watches the output of an infrared or UHF receiver front end that has already stripped the carrier. For each symbol it measures two durations: how long the input stays active (the mark), and the full symbol period, from the start of that mark to the start of the next one. Software recovers the space as the symbol minus the mark. Counts are in sample ticks. A programmable integer divisor derives the tick from the system clock, and the usual choice gives a 10 MHz tick.

Measured pairs queue in a small FIFO that software drains through a simple word-addressed register port. A pulse train ends when the input stays idle for longer than a programmable maximum symbol period. The last mark is then stored with an all-ones symbol value as an end-of-train marker, and the receiver waits for the next active edge. Four interrupt sources feed sticky status bits: data stored, end of train, overrun and FIFO full. Each source has its own enable bit and is cleared by writing a one.

Register words (regAddr): 0x0 control, 0x1 tick divisor, 0x2 maximum symbol period, 0x3 interrupt enable, 0x4 interrupt status, 0x5 interrupt clear, 0x6 receive status, 0x7 mark, 0x8 symbol. Other addresses read as zero. Read data appears on regRdata one clock after the cycle in which regRd is high.

Top module: `irSymbolCapture`

## Requirements
- R1: With divisor D in word 0x1 (a value of 0 acts as 1), a mark lasting H clocks followed by a mark start P clocks after the first one yields an entry with mark floor(H/D) and symbol floor(P/D).
- R2: Once the ticks counted since the last mark start reach the value in word 0x2 while the input is inactive, an entry is stored holding that mark and an all-ones symbol (0xFFFF at the default 16-bit width). The receiver then stores nothing more until the next active edge.
- R3: Bit 1 of word 0x0 set to 1 makes a low input the active (mark) level. Cleared, a high input is active.
- R4: Bit 0 of word 0x0 enables capture. While it is 0, no entry is stored and no interrupt status bit is set.
- R5: The FIFO holds FIFO_DEPTH entries in arrival order. A read of word 0x8 returns the oldest symbol and removes that entry. A following read of word 0x7 returns the same entry's mark. A read of word 0x8 on an empty FIFO returns 0 and removes nothing.
- R6: An entry completed while the FIFO is full is dropped and sets the overrun flag. The flag stays set until software clears it.
- R7: Word 0x6 reports the number of stored entries in bits 15:8 and the overrun flag in bit 2. It is zero after reset.
- R8: Word 0x4 holds sticky status bits: bit 0 is set when an entry is stored, bit 1 when an end-of-train entry is stored, bit 2 on overrun, and bit 3 when the FIFO becomes full. Writing ones to word 0x5 clears only the matching bits. All are zero after reset.
- R9: The irq output is high exactly when some status bit is set whose enable bit in word 0x3 (same layout) is also set.
- R10: Mark and symbol counts saturate at all ones instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| irPin | input | 1 | Demodulated receiver input |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe |
| regAddr | input | 4 | Register word address |
| regWdata | input | DATA_W | Write data |
| regRdata | output | DATA_W | Read data, valid the cycle after regRd |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with a 10-bit count width (CNT_W=10), the default 8-entry FIFO and a 32-bit data bus. The narrow counters make saturation reachable: a single long mark of about a thousand clocks drives the count to all ones and still leaves room for random pulse trains at divisors 0 to 5. Ten-symbol trains overflow the eight-entry FIFO, which exposes the drop, overrun and full paths and the order in which surviving entries drain.

// File: rtl/irCapPkg.sv
package irCapPkg;

  // register word addresses
  localparam logic [3:0] ADDR_CTRL    = 4'h0;
  localparam logic [3:0] ADDR_DIV     = 4'h1;
  localparam logic [3:0] ADDR_MAXPER  = 4'h2;
  localparam logic [3:0] ADDR_IRQEN   = 4'h3;
  localparam logic [3:0] ADDR_IRQSTAT = 4'h4;
  localparam logic [3:0] ADDR_IRQCLR  = 4'h5;
  localparam logic [3:0] ADDR_RXSTAT  = 4'h6;
  localparam logic [3:0] ADDR_MARK    = 4'h7;
  localparam logic [3:0] ADDR_SYMBOL  = 4'h8;

  // interrupt status / enable bit positions
  localparam int IRQ_DATA = 0;
  localparam int IRQ_LAST = 1;
  localparam int IRQ_OVR  = 2;
  localparam int IRQ_FULL = 3;
  localparam int IRQ_N    = 4;

  // receive status layout
  localparam int RXST_OVR_BIT = 2;
  localparam int RXST_LVL_LSB = 8;

  // control -> datapath strobes
  typedef struct packed {
    logic enable;
    logic invert;
    logic pop;
  } capCmd_t;

  // datapath -> control event strobes
  typedef struct packed {
    logic pushed;
    logic lastSym;
    logic dropped;
    logic becameFull;
  } capEvt_t;

  typedef enum logic {RX_IDLE, RX_MEAS} rxState_e;

endpackage

// File: rtl/irCapFifo.sv
module irCapFifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic [W-1:0]     din,
  output logic [W-1:0]     dout,
  output logic [LVL_W-1:0] level
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [W-1:0]     store [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) store[wrPtr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (push) wrPtr <= nextPtr(wrPtr);
      if (pop)  rdPtr <= nextPtr(rdPtr);
      if (push && !pop)      level <= level + 1'b1;
      else if (pop && !push) level <= level - 1'b1;
    end
  end

  assign dout = store[rdPtr];
endmodule

// File: rtl/irCapDatapath.sv
module irCapDatapath
  import irCapPkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DIV_W = 8,
  parameter int DEPTH = 8,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             irPin,
  input  capCmd_t          cmd,
  input  logic [DIV_W-1:0] divisor,
  input  logic [CNT_W-1:0] maxPer,
  output capEvt_t          evt,
  output logic [CNT_W-1:0] headMark,
  output logic [CNT_W-1:0] headSym,
  output logic [LVL_W-1:0] level
);
  localparam int ENTRY_W = 2 * CNT_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(DEPTH);
  localparam logic [LVL_W-1:0] LVL_ALMOST = LVL_W'(DEPTH - 1);

  // input synchroniser and edge detect
  logic [1:0] syncQ;
  logic       lvl, lvlQ, rise, fall;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ <= '0;
      lvlQ  <= 1'b0;
    end else begin
      syncQ <= {syncQ[0], irPin};
      lvlQ  <= lvl;
    end
  end

  assign lvl  = syncQ[1] ^ cmd.invert;
  assign rise = lvl & ~lvlQ;
  assign fall = ~lvl & lvlQ;

  // sample tick prescaler, realigned at each mark start
  logic [DIV_W-1:0] preCnt, divEff;
  logic             tick;

  assign divEff = (divisor == '0) ? DIV_W'(1) : divisor;
  assign tick   = (preCnt == divEff - 1'b1);

  always_ff @(posedge clk) begin
    if (!rstN)                    preCnt <= '0;
    else if (!cmd.enable || rise) preCnt <= '0;
    else if (tick)                preCnt <= '0;
    else                          preCnt <= preCnt + 1'b1;
  end

  // measurement state machine
  rxState_e         state;
  logic [CNT_W-1:0] markCnt, symCnt, symNow, pushSym;
  logic             inMark, timeout, pushReq, canPush, pushOk;

  function automatic logic [CNT_W-1:0] satInc(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + 1'b1;
  endfunction

  assign symNow  = tick ? satInc(symCnt) : symCnt;
  assign timeout = (state == RX_MEAS) && !inMark && !rise && (symCnt >= maxPer);
  assign pushReq = cmd.enable && (state == RX_MEAS) && (rise || timeout);
  assign pushSym = timeout ? CNT_MAX : symNow;

  always_ff @(posedge clk) begin
    if (!rstN || !cmd.enable) begin
      state   <= RX_IDLE;
      markCnt <= '0;
      symCnt  <= '0;
      inMark  <= 1'b0;
    end else begin
      unique case (state)
        RX_IDLE: begin
          if (rise) begin
            state   <= RX_MEAS;
            markCnt <= '0;
            symCnt  <= '0;
            inMark  <= 1'b1;
          end
        end
        RX_MEAS: begin
          if (rise) begin
            markCnt <= '0;
            symCnt  <= '0;
            inMark  <= 1'b1;
          end else if (timeout) begin
            state  <= RX_IDLE;
            inMark <= 1'b0;
          end else begin
            if (fall) inMark <= 1'b0;
            if (tick) begin
              symCnt <= satInc(symCnt);
              if (inMark) markCnt <= satInc(markCnt);
            end
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  // FIFO write side
  assign canPush = (level != LVL_FULL) || cmd.pop;
  assign pushOk  = pushReq && canPush;

  assign evt.pushed     = pushOk;
  assign evt.lastSym    = pushOk && timeout;
  assign evt.dropped    = pushReq && !canPush;
  assign evt.becameFull = pushOk && !cmd.pop && (level == LVL_ALMOST);

  logic [ENTRY_W-1:0] headEntry;

  irCapFifo #(.W(ENTRY_W), .DEPTH(DEPTH), .LVL_W(LVL_W)) uFifo (
    .clk  (clk),
    .rstN (rstN),
    .push (pushOk),
    .pop  (cmd.pop),
    .din  ({markCnt, pushSym}),
    .dout (headEntry),
    .level(level)
  );

  assign headMark = headEntry[ENTRY_W-1:CNT_W];
  assign headSym  = headEntry[CNT_W-1:0];
endmodule

// File: rtl/irCapCtrl.sv
module irCapCtrl
  import irCapPkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DIV_W  = 8,
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [3:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              irq,
  output capCmd_t           cmd,
  output logic [DIV_W-1:0]  divisor,
  output logic [CNT_W-1:0]  maxPer,
  input  capEvt_t           evt,
  input  logic [CNT_W-1:0]  headMark,
  input  logic [CNT_W-1:0]  headSym,
  input  logic [LVL_W-1:0]  level
);
  logic              enableQ, invertQ;
  logic [IRQ_N-1:0]  irqEnQ, irqStatQ, setV, clrV;
  logic [CNT_W-1:0]  markHoldQ;
  logic [DATA_W-1:0] rdNext, rdataQ;
  logic              notEmpty, popNow;
  logic              unusedWdata;

  assign unusedWdata = ^regWdata;
  assign notEmpty = (level != '0);
  assign popNow   = regRd && (regAddr == ADDR_SYMBOL) && notEmpty;

  assign cmd.enable = enableQ;
  assign cmd.invert = invertQ;
  assign cmd.pop    = popNow;

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableQ <= 1'b0;
      invertQ <= 1'b0;
      divisor <= DIV_W'(1);
      maxPer  <= '1;
      irqEnQ  <= '0;
    end else if (regWr) begin
      unique case (regAddr)
        ADDR_CTRL: begin
          enableQ <= regWdata[0];
          invertQ <= regWdata[1];
        end
        ADDR_DIV:    divisor <= regWdata[DIV_W-1:0];
        ADDR_MAXPER: maxPer  <= regWdata[CNT_W-1:0];
        ADDR_IRQEN:  irqEnQ  <= regWdata[IRQ_N-1:0];
        default: ;
      endcase
    end
  end

  // sticky interrupt status, set wins over clear
  always_comb begin
    setV = '0;
    setV[IRQ_DATA] = evt.pushed;
    setV[IRQ_LAST] = evt.lastSym;
    setV[IRQ_OVR]  = evt.dropped;
    setV[IRQ_FULL] = evt.becameFull;
    clrV = (regWr && (regAddr == ADDR_IRQCLR)) ? regWdata[IRQ_N-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) irqStatQ <= '0;
    else       irqStatQ <= (irqStatQ & ~clrV) | setV;
  end

  assign irq = |(irqStatQ & irqEnQ);

  // holding register for the mark of the last popped entry
  always_ff @(posedge clk) begin
    if (!rstN)       markHoldQ <= '0;
    else if (popNow) markHoldQ <= headMark;
  end

  // read mux
  always_comb begin
    rdNext = '0;
    unique case (regAddr)
      ADDR_CTRL:    rdNext[1:0] = {invertQ, enableQ};
      ADDR_DIV:     rdNext[DIV_W-1:0] = divisor;
      ADDR_MAXPER:  rdNext[CNT_W-1:0] = maxPer;
      ADDR_IRQEN:   rdNext[IRQ_N-1:0] = irqEnQ;
      ADDR_IRQSTAT: rdNext[IRQ_N-1:0] = irqStatQ;
      ADDR_RXSTAT: begin
        rdNext[RXST_LVL_LSB +: LVL_W] = level;
        rdNext[RXST_OVR_BIT]          = irqStatQ[IRQ_OVR];
      end
      ADDR_MARK:    rdNext[CNT_W-1:0] = markHoldQ;
      ADDR_SYMBOL:  if (notEmpty) rdNext[CNT_W-1:0] = headSym;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)      rdataQ <= '0;
    else if (regRd) rdataQ <= rdNext;
  end

  assign regRdata = rdataQ;
endmodule

// File: rtl/irSymbolCapture.sv
module irSymbolCapture
  import irCapPkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int DIV_W      = 8,
  parameter int FIFO_DEPTH = 8,
  parameter int DATA_W     = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              irPin,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [3:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              irq
);
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

  capCmd_t          cmdBus;
  capEvt_t          evtBus;
  logic [DIV_W-1:0] divisor;
  logic [CNT_W-1:0] maxPer, headMark, headSym;
  logic [LVL_W-1:0] fifoLevel;

  irCapCtrl #(
    .CNT_W(CNT_W), .DIV_W(DIV_W), .DEPTH(FIFO_DEPTH),
    .DATA_W(DATA_W), .LVL_W(LVL_W)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .regWr   (regWr),
    .regRd   (regRd),
    .regAddr (regAddr),
    .regWdata(regWdata),
    .regRdata(regRdata),
    .irq     (irq),
    .cmd     (cmdBus),
    .divisor (divisor),
    .maxPer  (maxPer),
    .evt     (evtBus),
    .headMark(headMark),
    .headSym (headSym),
    .level   (fifoLevel)
  );

  irCapDatapath #(
    .CNT_W(CNT_W), .DIV_W(DIV_W), .DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .irPin   (irPin),
    .cmd     (cmdBus),
    .divisor (divisor),
    .maxPer  (maxPer),
    .evt     (evtBus),
    .headMark(headMark),
    .headSym (headSym),
    .level   (fifoLevel)
  );
endmodule

// File: rtl/irCapChecker.sv
module irCapChecker
  import irCapPkg::*;
#(
  parameter int DEPTH = 8,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             irq,
  input logic             regWr,
  input capCmd_t          cmd,
  input capEvt_t          evt,
  input logic [LVL_W-1:0] level
);
  localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(DEPTH);

  AST_NO_CAPTURE_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.enable |-> !(evt.pushed || evt.dropped)); // R4

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    level <= LVL_FULL); // R5

  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rstN)
    (evt.pushed && !cmd.pop) |=> (level == LVL_W'($past(level) + 1'b1))); // R5

  AST_DROP_ONLY_FULL: assert property (@(posedge clk) disable iff (!rstN)
    evt.dropped |-> (level == LVL_FULL && !cmd.pop)); // R6

  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past((evt != '0) || regWr)); // R9
endmodule

bind irSymbolCapture irCapChecker #(.DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) uChk (
  .clk  (clk),
  .rstN (rstN),
  .irq  (irq),
  .regWr(regWr),
  .cmd  (cmdBus),
  .evt  (evtBus),
  .level(fifoLevel)
);

// File: tb/sim_irSymbolCapture.sv
module sim_irSymbolCapture;
  localparam int CW    = 10;
  localparam int DEPTH = 8;
  localparam int DATAW = 32;
  localparam int ALL1  = (1 << CW) - 1;
  localparam int MAXP  = 200;

  logic clk = 1'b0, rstN = 1'b0, irPin = 1'b0, regWr = 1'b0, regRd = 1'b0;
  logic [3:0]       regAddr = '0;
  logic [DATAW-1:0] regWdata = '0;
  wire  [DATAW-1:0] regRdata;
  wire              irq;

  always #4 clk = ~clk;

  irSymbolCapture #(.CNT_W(CW), .DIV_W(8), .FIFO_DEPTH(DEPTH), .DATA_W(DATAW)) u0 (
    .clk(clk), .rstN(rstN), .irPin(irPin), .regWr(regWr), .regRd(regRd),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata), .irq(irq)
  );

  int errors = 0, checks = 0;
  bit finished = 0;
  bit activeLvl = 1'b1;
  int hArr[16], lArr[16], expMark[16], expSym[16];
  logic [31:0] rv;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    regRd = 1'b1; regAddr = a;
    @(negedge clk);
    regRd = 1'b0;
    d = regRdata;
  endtask

  function automatic int sat(input int v);
    return (v > ALL1) ? ALL1 : v;
  endfunction

  // drive n marks from hArr/lArr, last one followed by a timeout gap
  task automatic driveTrain(input int n, input int d);
    for (int i = 0; i < n; i++) begin
      irPin = activeLvl;
      repeat (hArr[i]) @(negedge clk);
      irPin = ~activeLvl;
      if (i < n - 1) repeat (lArr[i]) @(negedge clk);
      else           repeat (MAXP * d + 40) @(negedge clk);
      expMark[i] = sat(hArr[i] / d);
      expSym[i]  = (i < n - 1) ? sat((hArr[i] + lArr[i]) / d) : ALL1;
    end
  endtask

  task automatic drain(input int stored, input string req);
    regRead(4'h6, rv);
    chk({req, " level"}, rv[15:8], stored);
    for (int i = 0; i < stored; i++) begin
      regRead(4'h8, rv);
      chk({req, " symbol"}, rv, expSym[i]);
      regRead(4'h7, rv);
      chk({req, " mark"}, rv, expMark[i]);
    end
    regRead(4'h6, rv);
    chk({req, " drained level"}, rv[15:8], 0);
    regWrite(4'h5, 32'hF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // reset state: R7 R8 R9
    regRead(4'h6, rv); chk("R7 reset rx status", rv, 0);
    regRead(4'h4, rv); chk("R8 reset irq status", rv, 0);
    chk("R9 reset irq", irq, 0);

    // empty symbol read: R5
    regRead(4'h8, rv); chk("R5 empty symbol read", rv, 0);
    regRead(4'h6, rv); chk("R5 empty level unchanged", rv, 0);

    regWrite(4'h2, MAXP);

    // random trains: R1 R2
    for (int t = 0; t < 6; t++) begin
      int dsel, n;
      dsel = (t == 0) ? 0 : 1 + int'($urandom % 5);
      n = 1 + int'($urandom % 6);
      for (int i = 0; i < n; i++) begin
        hArr[i] = 3 + int'($urandom % 58);
        lArr[i] = 3 + int'($urandom % 58);
      end
      regWrite(4'h1, dsel);
      regWrite(4'h0, 32'h1);
      driveTrain(n, (dsel == 0) ? 1 : dsel);
      // R2 idle after timeout: nothing more arrives
      repeat (300) @(negedge clk);
      regRead(4'h4, rv);
      chk("R2 end-of-train status", rv[1:0], 2'b11);
      drain(n, "R1 R2 train");
      regWrite(4'h0, 32'h0);
    end

    // polarity inversion: R3
    regWrite(4'h1, 2);
    irPin = 1'b1;
    activeLvl = 1'b0;
    regWrite(4'h0, 32'h3);
    hArr[0] = 20; lArr[0] = 30; hArr[1] = 41; lArr[1] = 9; hArr[2] = 7;
    driveTrain(3, 2);
    drain(3, "R3 inverted");
    regWrite(4'h0, 32'h0);
    activeLvl = 1'b1;
    irPin = 1'b0;

    // disabled: R4
    regWrite(4'h1, 1);
    regWrite(4'h0, 32'h0);
    hArr[0] = 10; lArr[0] = 10; hArr[1] = 10; lArr[1] = 10; hArr[2] = 10;
    driveTrain(3, 1);
    regRead(4'h6, rv); chk("R4 no entries when disabled", rv, 0);
    regRead(4'h4, rv); chk("R4 no status when disabled", rv, 0);

    // overrun and full: R6 R7 R8
    regWrite(4'h0, 32'h1);
    for (int i = 0; i < 10; i++) begin hArr[i] = 5 + i; lArr[i] = 10; end
    driveTrain(10, 1);
    regRead(4'h6, rv);
    chk("R6 overrun flag in rx status", rv[2], 1);
    chk("R7 full level", rv[15:8], DEPTH);
    regRead(4'h4, rv); chk("R8 status after overrun", rv, 32'hD);
    regWrite(4'h5, 32'h4);
    regRead(4'h4, rv); chk("R8 clear only overrun", rv, 32'h9);
    regRead(4'h6, rv); chk("R6 overrun cleared", rv[2], 0);
    drain(DEPTH, "R6 kept oldest");

    // interrupt masking: R9 R8
    regWrite(4'h3, 32'h2);
    irPin = 1'b1; repeat (12) @(negedge clk);
    irPin = 1'b0; repeat (12) @(negedge clk);
    irPin = 1'b1; repeat (12) @(negedge clk);
    irPin = 1'b0; repeat (10) @(negedge clk);
    regRead(4'h4, rv); chk("R8 data bit set", rv, 32'h1);
    chk("R9 masked source keeps irq low", irq, 0);
    repeat (MAXP + 40) @(negedge clk);
    chk("R9 enabled source raises irq", irq, 1);
    regRead(4'h4, rv); chk("R8 status both", rv, 32'h3);
    regWrite(4'h5, 32'h2);
    chk("R9 irq drops after clear", irq, 0);
    regRead(4'h4, rv); chk("R8 w1c leaves other bit", rv, 32'h1);
    expMark[0] = 12; expSym[0] = 24; expMark[1] = 12; expSym[1] = ALL1;
    drain(2, "R5 masked train");
    regWrite(4'h3, 32'h0);

    // saturation: R10
    hArr[0] = 1100;
    driveTrain(1, 1);
    drain(1, "R10 saturated mark");

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule